// File: doc/BRIEF.md
# Enable-Gated Bus ALU

This block is a purely combinational arithmetic/logic unit for a single-bus datapath. It takes two register operands, X and Y, and gates each one with its own active-high enable. A zero enable forces that operand to zero before anything else happens. Each gated operand can then be inverted. A function select picks either the sum or the bitwise AND of the two prepared operands, and a final inversion can be applied to that result. Together these controls give sums, ANDs, ORs, differences, negations, pass-through of either operand and small constants.

The adder's carry input comes from a stored carry flag. It is used only when a separate carry-use control line is also high, so a stale flag cannot disturb an operation that did not ask for it. The block also produces a carry-out and a zero indication for an external flags register to capture. The result reaches the shared bus only while the output enable is high. At all other times the block leaves the bus released, so another module can drive it.

Top module: `enbus_alu`

## Requirements
- R1: When `x_en` is 0 the X operand is treated as zero whatever `x_i` holds, and likewise `y_en` with `y_i`. Gating happens before inversion.
- R2: With `op_add` = 1 the result is the sum of the prepared operands plus the carry input, modulo 2^16. With `op_add` = 0 the result is their bitwise AND.
- R3: The adder's carry input is 1 only when both `cflag_i` and `cuse_i` are 1. If either is 0 the carry input is 0.
- R4: `x_neg` and `y_neg` bitwise-invert their gated operand, and `res_neg` bitwise-inverts the function result. This gives X|Y from AND with all three set, and X-Y from addition with `x_neg` and `res_neg` set.
- R5: While `bus_oe` is 1 the bus carries the result. While `bus_oe` is 0 the block drives nothing, and a value driven by another source is read back unchanged.
- R6: `carry_o` equals the carry out of the top adder bit, taken before output inversion, when `op_add` = 1. It is 0 when `op_add` = 0.
- R7: `zero_o` is 1 exactly when all 16 bits of the result are 0. This holds whatever the value of `bus_oe`.
- R8: Selecting addition with one operand disabled, no inversions and no carry passes the other operand to the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 16 | X register operand |
| y_i | input | 16 | Y register operand |
| x_en | input | 1 | Enable for X; 0 forces the operand to zero |
| y_en | input | 1 | Enable for Y; 0 forces the operand to zero |
| x_neg | input | 1 | Invert gated X |
| y_neg | input | 1 | Invert gated Y |
| op_add | input | 1 | 1 = add, 0 = bitwise AND |
| res_neg | input | 1 | Invert the function result |
| cflag_i | input | 1 | Stored carry flag |
| cuse_i | input | 1 | Carry-use control; allows the flag into the adder |
| bus_oe | input | 1 | Drive the result onto the bus |
| bus_io | inout | 16 | Shared data bus |
| carry_o | output | 1 | Adder carry-out, 0 in AND mode |
| zero_o | output | 1 | Result is all zero |

## Verification
The embedded assertions check, on every evaluation, that the bus matches the result while it is driven and agrees with the zero indication. They also check that the carry-out is silent in AND mode, that disabled operands under AND give zero, that pass-through holds and that a gated-off carry adds nothing. The correct arithmetic values of sums, differences, negations, OR and carry-out on overflow, and the bus being released to another driver, can only be shown by the bench's vector table and directed scenarios.

// File: rtl/enbus_alu_pkg.sv
package enbus_alu_pkg;
  localparam int ALU_W_DEF = 16;
  localparam int N_OPND    = 2;
  localparam int OPND_X    = 0;
  localparam int OPND_Y    = 1;

  typedef struct packed {
    logic en;
    logic neg;
  } opnd_ctrl_t;
endpackage

// File: rtl/enbus_alu_opnd.sv
module enbus_alu_opnd #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  enbus_alu_pkg::opnd_ctrl_t ctl_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] gated;

  always_comb begin
    gated = val_i & {W{ctl_i.en}};
    val_o = gated ^ {W{ctl_i.neg}};
  end
endmodule

// File: rtl/enbus_alu_func.sv
module enbus_alu_func #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         add_i,
  input  logic         cin_i,
  input  logic         neg_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int SW = W + 1;

  logic [SW-1:0] sum_ext;
  logic [W-1:0]  pre;

  always_comb begin
    sum_ext = {1'b0, a_i} + {1'b0, b_i} + {{(SW-1){1'b0}}, cin_i};
    pre     = add_i ? sum_ext[W-1:0] : (a_i & b_i);
    res_o   = pre ^ {W{neg_i}};
    cout_o  = add_i & sum_ext[W];
  end
endmodule

// File: rtl/enbus_alu_drv.sv
module enbus_alu_drv #(
  parameter int W = 16
) (
  input  logic [W-1:0] res_i,
  input  logic         oe_i,
  inout  wire  [W-1:0] bus_io
);
  assign bus_io = oe_i ? res_i : {W{1'bz}};
endmodule

// File: rtl/enbus_alu.sv
module enbus_alu #(
  parameter int W = enbus_alu_pkg::ALU_W_DEF
) (
  input  logic [15:0] x_i,
  input  logic [15:0] y_i,
  input  logic        x_en,
  input  logic        y_en,
  input  logic        x_neg,
  input  logic        y_neg,
  input  logic        op_add,
  input  logic        res_neg,
  input  logic        cflag_i,
  input  logic        cuse_i,
  input  logic        bus_oe,
  inout  wire  [15:0] bus_io,
  output logic        carry_o,
  output logic        zero_o
);
  import enbus_alu_pkg::*;

  logic [N_OPND-1:0][W-1:0] raw;
  logic [N_OPND-1:0][W-1:0] prep;
  opnd_ctrl_t [N_OPND-1:0]  ctl;
  logic [W-1:0]             result;
  logic                     cin;

  always_comb begin
    raw[OPND_X]     = x_i[W-1:0];
    raw[OPND_Y]     = y_i[W-1:0];
    ctl[OPND_X].en  = x_en;
    ctl[OPND_X].neg = x_neg;
    ctl[OPND_Y].en  = y_en;
    ctl[OPND_Y].neg = y_neg;
    cin             = cflag_i & cuse_i;
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    enbus_alu_opnd #(.W(W)) opnd_i (
      .val_i (raw[g]),
      .ctl_i (ctl[g]),
      .val_o (prep[g])
    );
  end

  enbus_alu_func #(.W(W)) func_i (
    .a_i    (prep[OPND_X]),
    .b_i    (prep[OPND_Y]),
    .add_i  (op_add),
    .cin_i  (cin),
    .neg_i  (res_neg),
    .res_o  (result),
    .cout_o (carry_o)
  );

  enbus_alu_drv #(.W(W)) drv_i (
    .res_i  (result),
    .oe_i   (bus_oe),
    .bus_io (bus_io)
  );

  always_comb zero_o = ~|result;

  // Checks across the gate, function and driver submodules.
  always_comb begin
    if (!op_add)
      assert_and_no_carry_R6: assert (!carry_o);
    if (!x_en && !x_neg && !op_add && !res_neg)
      assert_gate_zero_R1: assert (result == '0);
    if (op_add && !x_en && !x_neg && !y_neg && !res_neg && !cuse_i)
      assert_pass_y_R8: assert (result == (y_i[W-1:0] & {W{y_en}}));
    if (op_add && !cuse_i && !x_en && !y_en && !x_neg && !y_neg && !res_neg)
      assert_cin_gated_R3: assert (result == '0 && !carry_o);
    if (bus_oe)
      assert_bus_drive_R5: assert (bus_io == result);
    if (bus_oe)
      assert_zero_flag_R7: assert (zero_o == (bus_io == '0));
  end
endmodule

// File: tb/enbus_alu_tb_top.sv
module enbus_alu_tb_top;
  logic clk;
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] x_i, y_i;
  logic x_en, y_en, x_neg, y_neg, op_add, res_neg, cflag_i, cuse_i, bus_oe;
  logic carry_o, zero_o;
  wire  [15:0] bus_w;
  logic        tb_drv;
  logic [15:0] tb_val;

  assign bus_w = tb_drv ? tb_val : 16'hzzzz;

  enbus_alu dut_i (
    .x_i(x_i), .y_i(y_i), .x_en(x_en), .y_en(y_en), .x_neg(x_neg),
    .y_neg(y_neg), .op_add(op_add), .res_neg(res_neg), .cflag_i(cflag_i),
    .cuse_i(cuse_i), .bus_oe(bus_oe), .bus_io(bus_w), .carry_o(carry_o),
    .zero_o(zero_o)
  );

  // ctrl bits: [7]x_en [6]y_en [5]x_neg [4]y_neg [3]op_add [2]res_neg [1]cflag [0]cuse
  // vector: {ctrl[7:0], x[15:0], y[15:0], exp_res[15:0], exp_c, exp_z}
  localparam int NV = 15;
  localparam logic [NV-1:0][57:0] VEC = '{
    {8'hC8, 16'h1234, 16'h1111, 16'h2345, 1'b0, 1'b0}, // R2 add
    {8'hC0, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0, 1'b0}, // R2 and
    {8'hF4, 16'h00F0, 16'h0F00, 16'h0FF0, 1'b0, 1'b0}, // R4 or
    {8'h88, 16'hBEEF, 16'h1234, 16'hBEEF, 1'b0, 1'b0}, // R8 pass x
    {8'h48, 16'hBEEF, 16'h1234, 16'h1234, 1'b0, 1'b0}, // R8 pass y, R1
    {8'hCB, 16'h0010, 16'h0001, 16'h0012, 1'b0, 1'b0}, // R3 carry used
    {8'hCA, 16'h0010, 16'h0001, 16'h0011, 1'b0, 1'b0}, // R3 flag, not used
    {8'hC9, 16'h0010, 16'h0001, 16'h0011, 1'b0, 1'b0}, // R3 use, no flag
    {8'hC8, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1}, // R6 R7 overflow
    {8'hC0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0}, // R6 no carry in and
    {8'hEC, 16'h0009, 16'h0003, 16'h0006, 1'b0, 1'b0}, // R4 x-y
    {8'hAB, 16'h0005, 16'h1234, 16'hFFFB, 1'b0, 1'b0}, // R4 R3 negate
    {8'h28, 16'hABCD, 16'h5555, 16'hFFFF, 1'b0, 1'b0}, // R1 R4 constant -1
    {8'h40, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b1}, // R1 R7 and zero
    {8'hEC, 16'h0003, 16'h0005, 16'hFFFE, 1'b1, 1'b0}  // R4 R6 x-y borrow
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    {x_en, y_en, x_neg, y_neg, op_add, res_neg, cflag_i, cuse_i} = c;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    x_i = 16'h0; y_i = 16'h0; set_ctrl(8'h00); bus_oe = 1'b0;
    tb_drv = 1'b1; tb_val = 16'h5A5A;
    @(negedge clk);
    // idle state: bus released, zero result flagged
    chk("R5 idle release", bus_w, 16'h5A5A);
    chk("R7 idle zero", {15'b0, zero_o}, 16'h1);
    chk("R6 idle carry", {15'b0, carry_o}, 16'h0);

    for (int i = NV - 1; i >= 0; i--) begin
      @(posedge clk);
      tb_drv = 1'b0; bus_oe = 1'b1;
      set_ctrl(VEC[i][57:50]);
      x_i = VEC[i][49:34];
      y_i = VEC[i][33:18];
      @(negedge clk);
      chk("R2/R4 result", bus_w, VEC[i][17:2]);
      chk("R6 carry", {15'b0, carry_o}, {15'b0, VEC[i][1]});
      chk("R7 zero", {15'b0, zero_o}, {15'b0, VEC[i][0]});
    end

    // R5: release with a nonzero result, other driver owns the bus
    @(posedge clk);
    bus_oe = 1'b0;
    set_ctrl(8'hC8); x_i = 16'h0100; y_i = 16'h0023;
    @(posedge clk);
    tb_drv = 1'b1; tb_val = 16'hC3C3;
    @(negedge clk);
    chk("R5 released", bus_w, 16'hC3C3);
    chk("R7 zero without oe", {15'b0, zero_o}, 16'h0);
    @(posedge clk);
    tb_drv = 1'b0;
    @(posedge clk);
    bus_oe = 1'b1;
    @(negedge clk);
    chk("R5 driven", bus_w, 16'h0123);

    // R7: zero result while bus released
    @(posedge clk);
    bus_oe = 1'b0; set_ctrl(8'hC0); x_i = 16'hAAAA; y_i = 16'h5555;
    tb_drv = 1'b1; tb_val = 16'hFFFF;
    @(negedge clk);
    chk("R7 zero released", {15'b0, zero_o}, 16'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule